// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits behind a two-wire serial memory front-end and handles write transfers into a byte-addressed nonvolatile array of 8192 bytes, arranged as 256 pages of 32 bytes. The front-end passes three things to it:

- a pulse that opens a write transfer;
- a 13-bit start address;
- the data bytes that follow.

The block gathers those bytes in a 32-entry page buffer. Each entry has its own valid flag. A 5-bit in-page offset advances after every byte and wraps inside the page.

When the front-end reports a STOP, the block may launch a programming cycle. It does so only if at least one byte was gathered and write protection is low. For a fixed number of clocks it then holds `busy_o` high. During this window it copies only the valid buffer entries to the array's write port, one per clock, in ascending offset order. Bytes of the page that were not written in the transfer are never touched.

While busy, the block refuses all traffic. Both ready outputs are low, and the start and STOP pulses are ignored. The front-end uses `busy_o` to stop acknowledging on the bus. The address and data inputs are valid/ready streams:

- A transfer happens in a cycle where valid and ready are both high.
- The sender must hold valid and the payload until that cycle.
- `addr_ready_o` is high whenever the block is not busy.
- `data_ready_o` is high only when the block is not busy and an address has been accepted in the current transfer.

The length of the programming window is the parameter `T_PROG`, counted in clocks. It must be at least `PAGE_BYTES`.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, `busy_o` and `data_ready_o` are low, `addr_ready_o` is high and `arr_we_o` is low.
- R2: An address handshake splits the address into a page number (bits 12:5) and a start offset (bits 4:0). `data_ready_o` rises only after an address has been accepted in the current transfer.
- R3: Each accepted data byte goes to the current offset, which then increments modulo 32. A transfer of more than 32 bytes therefore overwrites earlier bytes of the same page, and the last value written to an offset wins.
- R4: During a commit, `arr_we_o` pulses once for each valid buffer entry, in ascending offset order, with `arr_addr_o` = {page, offset}. Array bytes not written in the transfer receive no write.
- R5: A launched commit raises `busy_o` in the cycle after the STOP and holds it for exactly `T_PROG` cycles.
- R6: While `busy_o` is high, `addr_ready_o` and `data_ready_o` are low, and the start and STOP pulses have no effect.
- R7: A STOP seen while `wp_i` is high starts no commit and raises no `busy_o`. `arr_we_o` is never high while `wp_i` is high.
- R8: A STOP with no data byte accepted in the transfer starts no commit and raises no `busy_o`.
- R9: A transfer-start pulse clears all valid flags. Bytes gathered in an earlier transfer that was never committed are never written.
- R10: A STOP ends the transfer. `data_ready_o` stays low until a new address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write protect; high blocks every array write |
| xfer_start_i | input | 1 | Pulse: a write transfer begins |
| stop_i | input | 1 | Pulse: STOP closes the transfer |
| addr_valid_i | input | 1 | Start address valid |
| addr_ready_o | output | 1 | Start address can be accepted |
| addr_i | input | 13 | Start word address |
| data_valid_i | input | 1 | Data byte valid |
| data_ready_o | output | 1 | Data byte can be accepted |
| data_i | input | 8 | Data byte |
| busy_o | output | 1 | Programming cycle in progress |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | 13 | Array write address |
| arr_wdata_o | output | 8 | Array write data |

## Verification
The hardest case to reach is a page buffer that still holds valid flags from a transfer that was closed under write protection and never committed. A following transfer to the same page must not commit that stale data.

The stimulus builds this case on purpose:
1. Fill four entries of a page.
2. Close the transfer with write protection high.
3. Lower protection and open a new transfer that writes one byte to another offset of the same page.

A shadow array built from the write port must then show only that single byte changed.

A behavioural model compared on every clock also covers two more cases. One is overflow past 32 bytes. The other is traffic offered during the busy window.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef logic [7:0] byte_t;

  function automatic int unsigned addr_bits(input int unsigned bytes);
    return $clog2(bytes);
  endfunction
endpackage

// File: rtl/pce_page_buf.sv
module pce_page_buf
  import pce_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned PW         = 8,
  parameter int unsigned OW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          addr_we_i,
  input  logic [PW+OW-1:0] addr_i,
  input  logic          data_we_i,
  input  byte_t         data_i,
  input  logic          end_i,
  input  logic [OW-1:0] rd_idx_i,
  output logic [PW-1:0] page_o,
  output logic          have_addr_o,
  output logic          any_valid_o,
  output logic          rd_valid_o,
  output byte_t         rd_data_o
);
  logic [PW-1:0]   page_q;
  logic [OW-1:0]   off_q;
  logic            have_q;
  logic [PAGE_BYTES-1:0] val_q;
  byte_t           buf_q [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      have_q <= 1'b0;
    end else begin
      if (clr_i || end_i) have_q <= 1'b0;
      if (addr_we_i) begin
        page_q <= addr_i[PW+OW-1:OW];
        off_q  <= addr_i[OW-1:0];
        have_q <= 1'b1;
      end else if (data_we_i) begin
        off_q <= off_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q[i] <= 1'b0;
        buf_q[i] <= '0;
      end else if (clr_i) begin
        val_q[i] <= 1'b0;
      end else if (data_we_i && off_q == OW'(i)) begin
        val_q[i] <= 1'b1;
        buf_q[i] <= data_i;
      end
    end
  end

  assign page_o      = page_q;
  assign have_addr_o = have_q;
  assign any_valid_o = |val_q;
  assign rd_valid_o  = val_q[rd_idx_i];
  assign rd_data_o   = buf_q[rd_idx_i];

  // R9: a start pulse leaves no stale entry behind
  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !any_valid_o);
  // R3: one accepted byte moves the offset by exactly one, wrapping in page
  p_offset_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we_i && !addr_we_i && !clr_i) |=> off_q == $past(off_q) + 1'b1);
endmodule

// File: rtl/pce_commit_seq.sv
module pce_commit_seq #(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned OW         = 5,
  parameter int unsigned T_PROG     = 300000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  output logic          busy_o,
  output logic          walk_o,
  output logic [OW-1:0] idx_o
);
  localparam int unsigned CW = $clog2(T_PROG + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(T_PROG - 1)) busy_q <= 1'b0;
      else                          cnt_q  <= cnt_q + 1'b1;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end

  assign busy_o = busy_q;
  assign walk_o = busy_q && (cnt_q < CW'(PAGE_BYTES));
  assign idx_o  = cnt_q[OW-1:0];

  // R5: independent run-length counter for the busy window
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == 32'(T_PROG));
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import pce_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 32,
  parameter int unsigned NUM_PAGES  = 256,
  parameter int unsigned T_PROG     = 300000,
  localparam int unsigned OW = addr_bits(PAGE_BYTES),
  localparam int unsigned AW = addr_bits(PAGE_BYTES * NUM_PAGES),
  localparam int unsigned PW = AW - OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_i,
  input  logic          xfer_start_i,
  input  logic          stop_i,
  input  logic          addr_valid_i,
  output logic          addr_ready_o,
  input  logic [AW-1:0] addr_i,
  input  logic          data_valid_i,
  output logic          data_ready_o,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic          arr_we_o,
  output logic [AW-1:0] arr_addr_o,
  output logic [7:0]    arr_wdata_o
);
  logic          busy, walk, have_addr, any_valid, rd_valid;
  logic [OW-1:0] idx;
  logic [PW-1:0] page;
  byte_t         rd_data;
  logic          start_ok, addr_hs, data_hs, stop_ok, launch;

  assign start_ok     = xfer_start_i && !busy;
  assign addr_ready_o = !busy;
  assign addr_hs      = addr_valid_i && addr_ready_o;
  assign data_ready_o = !busy && have_addr;
  assign data_hs      = data_valid_i && data_ready_o;
  assign stop_ok      = stop_i && !busy;
  assign launch       = stop_ok && any_valid && !wp_i;

  pce_page_buf #(.PAGE_BYTES(PAGE_BYTES), .PW(PW), .OW(OW)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_ok),
    .addr_we_i  (addr_hs),
    .addr_i     (addr_i),
    .data_we_i  (data_hs),
    .data_i     (data_i),
    .end_i      (stop_ok),
    .rd_idx_i   (idx),
    .page_o     (page),
    .have_addr_o(have_addr),
    .any_valid_o(any_valid),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data)
  );

  pce_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .OW(OW), .T_PROG(T_PROG)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch_i(launch),
    .busy_o  (busy),
    .walk_o  (walk),
    .idx_o   (idx)
  );

  assign busy_o      = busy;
  assign arr_we_o    = walk && rd_valid && !wp_i;
  assign arr_addr_o  = {page, idx};
  assign arr_wdata_o = rd_data;

  // R7: protect input gates every array write
  p_no_write_wp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !arr_we_o);
  // R6: no traffic accepted during the programming window
  p_ready_low_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!addr_ready_o && !data_ready_o));
  // R5, R7: busy rises only after an unprotected STOP
  p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(stop_i) && !$past(wp_i)));
  // R4: array writes only inside the busy window
  p_we_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);
  // R10: data is refused in the cycle after a STOP
  p_stop_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !busy_o && !addr_valid_i) |=> !data_ready_o);
endmodule

// File: tb/sim_page_commit_engine.sv
module sim_page_commit_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TP = 40;
  localparam int PB = 32;

  logic clk = 0, rst_n = 0;
  logic wp = 0, xs = 0, stp = 0, av = 0, dv = 0;
  logic [12:0] addr = '0;
  logic [7:0]  din = '0;
  logic ar, dr, busy, we;
  logic [12:0] waddr;
  logic [7:0]  wdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_commit_engine #(.PAGE_BYTES(PB), .NUM_PAGES(256), .T_PROG(TP)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .xfer_start_i(xs), .stop_i(stp),
    .addr_valid_i(av), .addr_ready_o(ar), .addr_i(addr),
    .data_valid_i(dv), .data_ready_o(dr), .data_i(din),
    .busy_o(busy), .arr_we_o(we), .arr_addr_o(waddr), .arr_wdata_o(wdata));

  // shadow of the array as seen through the write port
  logic [7:0] dmem [int];
  always @(posedge clk) if (rst_n && we) dmem[int'(waddr)] = wdata;

  function automatic logic [7:0] rd(input int a);
    return dmem.exists(a) ? dmem[a] : 8'h00;
  endfunction

  // behavioural reference model
  bit m_busy, m_have;
  int m_cnt, m_page, m_off;
  bit m_val [PB];
  logic [7:0] m_buf [PB];

  function automatic bit m_any();
    for (int i = 0; i < PB; i++) if (m_val[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_have = 0; m_cnt = 0; m_page = 0; m_off = 0;
      for (int i = 0; i < PB; i++) begin m_val[i] = 0; m_buf[i] = 0; end
    end else if (m_busy) begin
      if (m_cnt == TP - 1) m_busy = 0; else m_cnt++;
    end else begin
      bit h0;
      h0 = m_have;
      if (xs) begin
        for (int i = 0; i < PB; i++) m_val[i] = 0;
        m_have = 0;
      end
      if (av) begin
        m_page = addr / PB; m_off = addr % PB; m_have = 1;
      end else if (dv && h0) begin
        m_val[m_off] = 1; m_buf[m_off] = din; m_off = (m_off + 1) % PB;
      end
      if (stp) begin
        if (m_any() && !wp) begin m_busy = 1; m_cnt = 0; end
        m_have = 0;
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    bit ewe;
    ewe = m_busy && m_cnt < PB && m_val[m_cnt % PB] && !wp;
    chk("R5/R6 busy_o", busy, m_busy);
    chk("R6 addr_ready_o", ar, !m_busy);
    chk("R2/R10 data_ready_o", dr, !m_busy && m_have);
    chk("R4 arr_we_o", we, ewe);
    if (ewe) begin
      chk("R4 arr_addr_o", waddr, m_page * PB + m_cnt);
      chk("R4 arr_wdata_o", wdata, m_buf[m_cnt]);
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic open_xfer(input int a);
    tick(); xs = 1;
    tick(); xs = 0; av = 1; addr = 13'(a);
    tick(); av = 0;
  endtask

  task automatic send(input int n, input int first);
    for (int k = 0; k < n; k++) begin
      dv = 1; din = 8'(first + k); tick();
    end
    dv = 0;
  endtask

  task automatic stop_pulse();
    stp = 1; tick(); stp = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; tick(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 addr_ready", ar, 1);
    chk("R1 data_ready", dr, 0); chk("R1 we", we, 0);

    // R2 single byte, R5 window length
    open_xfer(13'h0123);
    chk("R2 data_ready after address", dr, 1);
    send(1, 8'h5A);
    stop_pulse();
    wait_idle(n);
    chk("R5 busy cycles", n, TP);
    chk("R2 single byte", rd(13'h0123), 8'h5A);
    chk("R4 neighbour untouched", rd(13'h0124), 8'h00);

    // R3 partial page with wrap from offset 30
    open_xfer(13'h1F5E);
    send(5, 8'hA0);
    stop_pulse(); wait_idle(n);
    chk("R3 wrap off30", rd(13'h1F5E), 8'hA0);
    chk("R3 wrap off31", rd(13'h1F5F), 8'hA1);
    chk("R3 wrap off0", rd(13'h1F40), 8'hA2);
    chk("R3 wrap off2", rd(13'h1F42), 8'hA4);
    chk("R3 wrap off3 untouched", rd(13'h1F43), 8'h00);

    // R3 overflow: 34 bytes into one page
    open_xfer(13'h1FE0);
    send(34, 8'h10);
    stop_pulse(); wait_idle(n);
    chk("R3 overflow off0", rd(13'h1FE0), 8'h30);
    chk("R3 overflow off1", rd(13'h1FE1), 8'h31);
    chk("R3 overflow off2", rd(13'h1FE2), 8'h12);
    chk("R3 overflow off31", rd(13'h1FFF), 8'h2F);

    // R4 preload page then partial rewrite
    open_xfer(13'h0400); send(32, 8'h01); stop_pulse(); wait_idle(n);
    open_xfer(13'h0405); send(2, 8'hC0); stop_pulse(); wait_idle(n);
    chk("R4 kept before", rd(13'h0404), 8'h05);
    chk("R4 new", rd(13'h0405), 8'hC0);
    chk("R4 kept after", rd(13'h0407), 8'h08);

    // R8 stop with no data
    open_xfer(13'h0600); stop_pulse();
    chk("R8 no busy", busy, 0);
    chk("R10 data_ready after stop", dr, 0);

    // R7 protected write, then R9 stale buffer
    open_xfer(13'h0800); send(4, 8'hAA);
    wp = 1; stop_pulse();
    chk("R7 no busy under protect", busy, 0);
    chk("R10 data_ready after stop", dr, 0);
    tick(); wp = 0;
    open_xfer(13'h080A); send(1, 8'h5C); stop_pulse();
    chk("R5 busy rises", busy, 1);
    // R6 traffic during busy is refused and ignored
    xs = 1; tick(); xs = 0;
    chk("R6 addr_ready low", ar, 0);
    av = 1; addr = 13'h0900; dv = 1; din = 8'hEE; tick(); tick();
    chk("R6 data_ready low", dr, 0);
    av = 0; dv = 0;
    stp = 1; tick(); stp = 0;
    wait_idle(n);
    chk("R9 new byte", rd(13'h080A), 8'h5C);
    chk("R9 stale off0", rd(13'h0800), 8'h00);
    chk("R9 stale off3", rd(13'h0803), 8'h00);
    chk("R6 no address latched", dr, 0);
    chk("R6 no write to 0x0900", rd(13'h0900), 8'h00);

    repeat (3) tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule